// File: doc/BRIEF.md
# Working Register File with Pointer Pair

This block holds the general-purpose working registers of a small 8-bit RISC core: 32 entries of 8 bits each. Two read ports return operands combinationally, and one write port stores a result on the rising clock edge. An operand fetch, an ALU operation and the write-back of its result therefore fit in one clock cycle.

The two top entries, 30 and 31, are also presented together as one 16-bit pointer. Entry 30 is the low byte and entry 31 is the high byte. The pointer is driven out so that the core can use it to fetch from program memory. It also drives an indirect read of the file itself. A pointer value inside the file returns the register at that index. Any larger value returns zero and raises an out-of-range flag.

The block has no sequencing states. It consists of a storage array, two operand read muxes and the pointer view. Reset is synchronous and active high. Reset takes priority over a write in the same cycle.

Top module: `ptr_regfile`

## Requirements
- R1: When `wr_en` is 1 at a rising clock edge and `rst` is 0, register `wr_addr` takes the value of `wr_data`.
- R2: `rd_a_data` and `rd_b_data` show, combinationally and independently, the registers selected by `rd_a_addr` and `rd_b_addr`.
- R3: If a read address equals `wr_addr` during a write cycle, that read returns the old value. The new value is visible from the next cycle.
- R4: When `wr_en` is 0, no register changes at the clock edge.
- R5: `ptr_val` equals `{reg[31], reg[30]}`, with register 31 in bits 15:8 and register 30 in bits 7:0. It follows a write to either register from the next cycle.
- R6: When `rst` is 1 at a rising edge, all 32 registers become 0x00, even if `wr_en` is 1 in that cycle.
- R7: When `ptr_val` is 0 to 31, `ind_data` equals register `ptr_val` and `ind_oor` is 0.
- R8: When `ptr_val` is 32 or more, `ind_data` is 0x00 and `ind_oor` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears every register |
| rd_a_addr | input | 5 | First operand register index |
| rd_a_data | output | 8 | First operand value |
| rd_b_addr | input | 5 | Second operand register index |
| rd_b_data | output | 8 | Second operand value |
| wr_addr | input | 5 | Result register index |
| wr_data | input | 8 | Result value |
| wr_en | input | 1 | Store `wr_data` at the next rising edge |
| ptr_val | output | 16 | Pointer formed from registers 31 (high byte) and 30 (low byte) |
| ind_data | output | 8 | Register selected by the pointer, or 0x00 when out of range |
| ind_oor | output | 1 | Pointer value lies beyond the last register |

## Verification
The assertions assume that `wr_en`, `wr_addr` and `wr_data` are stable and known around each rising edge. They also assume that `rst` is held high through the first edge, so that every register has a defined value before any property looks at it. The stimulus changes inputs only on the falling edge and starts with two reset cycles. Writes to entries 30 and 31 steer the pointer across the boundary between 31 and 32, to its own two entries, and to 0xFFFF. A reset is applied with a write pending, to show that reset has priority.

// File: rtl/prf_pkg.sv
package prf_pkg;
    localparam int unsigned PRF_DATA_W = 8;
    localparam int unsigned PRF_DEPTH  = 32;
    localparam int unsigned PRF_PTR_LO = 30;
    localparam int unsigned PRF_PTR_HI = 31;
endpackage

// File: rtl/prf_store.sv
module prf_store #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 32,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [DEPTH-1:0][DATA_W-1:0]  regs_q
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
                regs_q[g] <= wr_data;
            end
        end
    end

    // R1: the addressed entry holds the written value one edge later
    p_write_lands_r1: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> regs_q[$past(wr_addr)] == $past(wr_data));

    // R4: the whole array is frozen without a write
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> regs_q == $past(regs_q));

    // R6: reset has cleared the array, pending write or not
    p_reset_clear_r6: assert property (@(posedge clk)
        $past(rst) |-> regs_q == '0);
endmodule

// File: rtl/prf_rdport.sv
module prf_rdport #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 32,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][DATA_W-1:0]  regs_q,
    input  logic [ADDR_W-1:0]             addr,
    output logic [DATA_W-1:0]             data
);
    always_comb begin
        data = regs_q[addr];
    end
endmodule

// File: rtl/prf_ptr.sv
module prf_ptr #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned PTR_LO = 30,
    parameter int unsigned PTR_HI = 31,
    localparam int unsigned ADDR_W = $clog2(DEPTH),
    localparam int unsigned PTR_W  = 2 * DATA_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [DEPTH-1:0][DATA_W-1:0]  regs_q,
    output logic [PTR_W-1:0]              ptr_val,
    output logic [DATA_W-1:0]             ind_data,
    output logic                          ind_oor
);
    logic in_file;

    always_comb begin
        ptr_val  = {regs_q[PTR_HI], regs_q[PTR_LO]};
        in_file  = ptr_val < PTR_W'(DEPTH);
        ind_oor  = !in_file;
        ind_data = in_file ? regs_q[ptr_val[ADDR_W-1:0]] : '0;
    end

    // R8: an out-of-range pointer never leaks register contents
    p_oor_zero_r8: assert property (@(posedge clk) disable iff (rst)
        ind_oor |-> ind_data == '0);

    // R7: an in-range pointer reads the file entry it names
    p_inrange_read_r7: assert property (@(posedge clk) disable iff (rst)
        !ind_oor |-> ind_data == regs_q[ptr_val[ADDR_W-1:0]]);
endmodule

// File: rtl/ptr_regfile.sv
module ptr_regfile
    import prf_pkg::*;
#(
    parameter int unsigned DATA_W = PRF_DATA_W,
    parameter int unsigned DEPTH  = PRF_DEPTH,
    parameter int unsigned PTR_LO = PRF_PTR_LO,
    parameter int unsigned PTR_HI = PRF_PTR_HI,
    localparam int unsigned ADDR_W = $clog2(DEPTH),
    localparam int unsigned PTR_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    output logic [PTR_W-1:0]  ptr_val,
    output logic [DATA_W-1:0] ind_data,
    output logic              ind_oor
);
    logic [DEPTH-1:0][DATA_W-1:0] regs_q;

    prf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .regs_q  (regs_q)
    );

    prf_rdport #(.DATA_W(DATA_W), .DEPTH(DEPTH)) rd_a_i (
        .regs_q (regs_q),
        .addr   (rd_a_addr),
        .data   (rd_a_data)
    );

    prf_rdport #(.DATA_W(DATA_W), .DEPTH(DEPTH)) rd_b_i (
        .regs_q (regs_q),
        .addr   (rd_b_addr),
        .data   (rd_b_data)
    );

    prf_ptr #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_LO(PTR_LO), .PTR_HI(PTR_HI)) ptr_i (
        .clk      (clk),
        .rst      (rst),
        .regs_q   (regs_q),
        .ptr_val  (ptr_val),
        .ind_data (ind_data),
        .ind_oor  (ind_oor)
    );

    // R3: a value written last cycle is what a matching read sees now
    p_written_visible_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_a_addr == wr_addr) |=>
            (rd_a_addr != $past(wr_addr)) || (rd_a_data == $past(wr_data)));

    // R5: writing the low pointer entry moves the pointer's low byte
    p_ptr_low_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(PTR_LO)) |=> ptr_val[DATA_W-1:0] == $past(wr_data));

    // R5: writing the high pointer entry moves the pointer's high byte
    p_ptr_high_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(PTR_HI)) |=> ptr_val[PTR_W-1:DATA_W] == $past(wr_data));
endmodule

// File: tb/ptr_regfile_tb.sv
module ptr_regfile_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       wr_en = 1'b0;
    logic [7:0] rd_a_data, rd_b_data, ind_data;
    logic [15:0] ptr_val;
    logic       ind_oor;

    int compared = 0;
    int mismatched = 0;
    int model [32];

    always #2 clk = ~clk;

    ptr_regfile dut_i (
        .clk(clk), .rst(rst),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
        .ptr_val(ptr_val), .ind_data(ind_data), .ind_oor(ind_oor)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // compare every output against the behavioural model
    task automatic compare_all(input string tag);
        int p;
        int e_ind;
        int e_oor;
        p = model[31] * 256 + model[30];
        e_ind = (p < 32) ? model[p] : 0;
        e_oor = (p < 32) ? 0 : 1;
        chk(tag, "rd_a_data", int'(rd_a_data), model[rd_a_addr]);
        chk(tag, "rd_b_data", int'(rd_b_data), model[rd_b_addr]);
        chk("R5", "ptr_val", int'(ptr_val), p);
        chk(p < 32 ? "R7" : "R8", "ind_data", int'(ind_data), e_ind);
        chk(p < 32 ? "R7" : "R8", "ind_oor", int'(ind_oor), e_oor);
    endtask

    // drive on the falling edge, compare mid-cycle, update model at the rising edge
    task automatic cyc(input string tag, input logic r, input logic we, input int wa,
                       input int wd, input int ra, input int rb);
        @(negedge clk);
        rst = r; wr_en = we; wr_addr = 5'(wa); wr_data = 8'(wd);
        rd_a_addr = 5'(ra); rd_b_addr = 5'(rb);
        #1;
        compare_all(tag);
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < 32; i++) model[i] = 0;
        end else if (we) begin
            model[wa] = wd;
        end
    endtask

    initial begin
        #400000;
        mismatched++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 0;
        // bring the file out of reset (R6); compare only once it is defined
        @(negedge clk); @(negedge clk);
        @(posedge clk);
        for (int i = 0; i < 32; i++) cyc("R6", 1'b1, 1'b0, 0, 0, i, 31 - i);
        // R1 and R2: fill the file with a pattern, reading two ports apart
        for (int i = 0; i < 32; i++) cyc("R1", 1'b0, 1'b1, i, (i * 37 + 11) & 8'hFF, (i + 5) % 32, (i + 17) % 32);
        for (int i = 0; i < 32; i++) cyc("R2", 1'b0, 1'b0, 0, 0, i, (i * 7) % 32);
        // R3: read the entry being written; old value now, new value next cycle
        cyc("R3", 1'b0, 1'b1, 9, 8'hA5, 9, 9);
        cyc("R3", 1'b0, 1'b0, 0, 0, 9, 9);
        // R4: data and address toggle with write disabled
        for (int i = 0; i < 8; i++) cyc("R4", 1'b0, 1'b0, i, 8'hFF - i, i, 31);
        // R5, R7, R8: steer the pointer
        cyc("R5", 1'b0, 1'b1, 31, 8'h00, 30, 31);
        cyc("R7", 1'b0, 1'b1, 30, 5, 30, 5);
        cyc("R7", 1'b0, 1'b1, 30, 31, 30, 31);
        cyc("R7", 1'b0, 1'b1, 30, 30, 30, 31);
        cyc("R7", 1'b0, 1'b1, 30, 0, 0, 30);
        cyc("R8", 1'b0, 1'b1, 30, 32, 30, 31);
        cyc("R8", 1'b0, 1'b1, 31, 8'h00, 30, 31);
        cyc("R8", 1'b0, 1'b1, 31, 8'hFF, 31, 30);
        cyc("R8", 1'b0, 1'b1, 30, 8'hFF, 31, 30);
        cyc("R5", 1'b0, 1'b1, 31, 8'h00, 31, 30);
        cyc("R7", 1'b0, 1'b1, 30, 12, 12, 30);
        cyc("R7", 1'b0, 1'b0, 0, 0, 12, 31);
        // R6: reset while a write is pending wins
        cyc("R6", 1'b1, 1'b1, 12, 8'h77, 12, 30);
        for (int i = 0; i < 32; i++) cyc("R6", 1'b0, 1'b0, 0, 0, i, 31 - i);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule